// File: doc/BRIEF.md
# Save Memory Busy-Time Controller

This block gives an emulated cartridge save device realistic busy periods. The emulating side hands it operations that are already decoded: chip erase, sector erase, program, or EEPROM write. For each accepted operation the block holds `busy` high for a number of clock cycles that the host has programmed for that operation class. It then raises a one-cycle `done` pulse. In SRAM mode there is no wait, and every operation completes at once.

The host programs four duration registers, an ownership bit and a reject-clear strobe through a simple write port. The ownership bit decides which master may reach the save array. While the host owns it, requests from the emulating side are blocked. A request that arrives while an operation is still running is dropped and sets a sticky reject flag.

Top module: `save_timing_ctrl`

## Requirements
- R1: After reset `busy`, `done` and `reject` are 0, `emu_grant` is 1 and `host_grant` is 0. All four duration registers hold 0.
- R2: A request is accepted when `op_req` is 1, `busy` is 0 and ownership is 0. The duration used is the register selected by `op_kind`: 0 chip erase, 1 sector erase, 2 program, 3 EEPROM write. Unless R4 applies, a duration N>0 makes `busy` high for exactly N cycles, starting the cycle after acceptance.
- R3: `done` is a one-cycle pulse. It comes in the first cycle after `busy` falls. For a zero duration it comes in the cycle after acceptance, and `busy` never rises.
- R4: When `cfg_dev_type` is 2 (SRAM), every accepted request gives `done` in the next cycle with no busy period, whatever the registers hold. The other type codes are 0 (4 Kbit EEPROM), 1 (64 Kbit EEPROM), 3 (512 Kbit flash) and 4 (1 Mbit flash, two 512 Kbit banks). These codes, and the unused codes 5 to 7, all use the programmed durations.
- R5: A request made while `busy` is 1 is ignored and does not change the running countdown. It sets `reject` from the next cycle on, and `reject` stays set.
- R6: A host write with `reg_sel`=5 clears `reject` in the next cycle. If a new reject event happens in the same cycle, the set wins.
- R7: A host write with `reg_sel`=4 stores `reg_wdata[0]` as the ownership bit from the next cycle on. When the bit is 0, `emu_grant` is 1. When the bit is 1, `host_grant` is 1.
- R8: While the ownership bit is 1, requests start no operation. They produce no `busy`, no `done` and no `reject`.
- R9: Host writes with `reg_sel` 0 to 3 store `reg_wdata` into the duration register of that operation class. A write made during an operation affects only later operations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_dev_type | input | 3 | Emulated device type code |
| reg_we | input | 1 | Host register write strobe |
| reg_sel | input | 3 | Host register select |
| reg_wdata | input | CNT_W | Host write data |
| op_req | input | 1 | Operation request from the emulating side |
| op_kind | input | 2 | Operation class of the request |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| reject | output | 1 | Sticky flag: a request arrived while busy |
| emu_grant | output | 1 | Emulating side owns the save array |
| host_grant | output | 1 | Host owns the save array |

## Verification
The outputs change at these points, counting clock edges:
- `busy` rises at the edge that accepts a request and falls N edges later.
- `done` is high for the single cycle after `busy` falls. For a zero duration it is high for the cycle after the accepting edge.
- `reject`, the grants and the register contents change one edge after the cycle that caused them.

The bench drives inputs and samples outputs on the falling edge. It counts the falling edges with `busy` high and compares that count with the duration a bench function derives from the mode and the registers. It checks `done` at the first falling edge with `busy` low and checks that `done` is gone one cycle later.

// File: rtl/save_timing_ctrl.sv
module save_timing_ctrl #(
  parameter int CNT_W = 32,
  parameter logic [2:0] SRAM_TYPE = 3'd2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       cfg_dev_type,
  input  logic             reg_we,
  input  logic [2:0]       reg_sel,
  input  logic [CNT_W-1:0] reg_wdata,
  input  logic             op_req,
  input  logic [1:0]       op_kind,
  output logic             busy,
  output logic             done,
  output logic             reject,
  output logic             emu_grant,
  output logic             host_grant
);
  localparam int NKIND = 4;

  logic [CNT_W-1:0] dur [NKIND];
  logic [CNT_W-1:0] cnt;
  logic             owner;

  wire accept = op_req && !busy && !owner;
  wire [CNT_W-1:0] load = (cfg_dev_type == SRAM_TYPE) ? '0 : dur[op_kind];

  assign emu_grant  = !owner;
  assign host_grant = owner;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      reject <= 1'b0;
      owner  <= 1'b0;
      cnt    <= '0;
      for (int i = 0; i < NKIND; i++) dur[i] <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        if (load == '0) done <= 1'b1;
        else begin
          busy <= 1'b1;
          cnt  <= load;
        end
      end else if (busy) begin
        if (cnt == CNT_W'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
        cnt <= cnt - 1'b1;
      end
      if (op_req && busy) reject <= 1'b1;
      else if (reg_we && reg_sel == 3'd5) reject <= 1'b0;
      if (reg_we && reg_sel == 3'd4) owner <= reg_wdata[0];
      if (reg_we && !reg_sel[2]) dur[reg_sel[1:0]] <= reg_wdata;
    end
  end

  // R3
  busy_end_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  // R5
  reject_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reject) |-> $past(op_req && busy));
  // R8
  owner_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_req && owner && !busy) |=> (!busy && !done));
  // R4
  sram_no_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cfg_dev_type == SRAM_TYPE) |=> (!busy && done));
  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && load != '0) |=> busy);
  // R7
  grant_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    emu_grant != host_grant);
endmodule

// File: tb/tb_save_timing_ctrl.sv
module tb_save_timing_ctrl;
  logic clk = 0, rst_n = 0;
  logic [2:0] cfg_dev_type = 0;
  logic reg_we = 0;
  logic [2:0] reg_sel = 0;
  logic [31:0] reg_wdata = 0;
  logic op_req = 0;
  logic [1:0] op_kind = 0;
  logic busy, done, reject, emu_grant, host_grant;
  int checks = 0, errors = 0, cyc = 0;
  logic [31:0] model_dur [4];

  always #2.5 clk = ~clk;

  save_timing_ctrl #(.CNT_W(32)) dut (.*);

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic int exp_len(input logic [2:0] t, input logic [1:0] k);
    return (t == 3'd2) ? 0 : int'(model_dur[k]);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] d);
    reg_we = 1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
    if (!sel[2]) model_dur[sel[1:0]] = d;
  endtask

  task automatic run_op(input logic [1:0] k, input int expn, input string req);
    int n = 0;
    op_kind = k; op_req = 1;
    @(negedge clk);
    op_req = 0;
    while (busy && n < 1000) begin n++; @(negedge clk); end
    chk(n == expn, req, n, expn);
    chk(done == 1, "R3 done after busy", done, 1);
    @(negedge clk);
    chk(done == 0, "R3 done single cycle", done, 0);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) model_dur[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !done && !reject, "R1 flags", {busy, done, reject}, 0);
    chk(emu_grant && !host_grant, "R1 grants", {emu_grant, host_grant}, 2);
    run_op(2'd0, 0, "R1 zero duration");

    for (int k = 0; k < 4; k++) wr(3'(k), 32'(3 + k * 2));
    cfg_dev_type = 3'd3;
    for (int k = 0; k < 4; k++) run_op(2'(k), exp_len(3'd3, 2'(k)), "R2 per-class length");
    cfg_dev_type = 3'd2;
    run_op(2'd1, 0, "R4 SRAM no wait");
    chk(busy == 0, "R4 no busy", busy, 0);

    // R9: register write during busy
    cfg_dev_type = 3'd4;
    wr(3'd2, 32'd8);
    begin
      int n = 0;
      op_kind = 2'd2; op_req = 1;
      @(negedge clk);
      op_req = 0;
      reg_we = 1; reg_sel = 3'd2; reg_wdata = 32'd2;
      @(negedge clk);
      reg_we = 0; model_dur[2] = 2; n = 1;
      while (busy && n < 1000) begin n++; @(negedge clk); end
      chk(n == 8, "R9 running op unaffected", n, 8);
    end
    @(negedge clk);
    run_op(2'd2, 2, "R9 new value used");

    // R5: request while busy
    wr(3'd3, 32'd10);
    cfg_dev_type = 3'd1;
    begin
      int n = 0;
      op_kind = 2'd3; op_req = 1;
      @(negedge clk);
      op_req = 0;
      repeat (3) begin n++; @(negedge clk); end
      op_kind = 2'd0; op_req = 1;
      @(negedge clk);
      op_req = 0; n++;
      chk(reject == 1, "R5 reject set", reject, 1);
      while (busy && n < 1000) begin n++; @(negedge clk); end
      chk(n == 10, "R5 countdown unchanged", n, 10);
      @(negedge clk);
      chk(reject == 1, "R5 reject sticky", reject, 1);
    end
    wr(3'd5, 0);
    chk(reject == 0, "R6 reject cleared", reject, 0);

    // R6: set wins over clear
    begin
      op_kind = 2'd3; op_req = 1;
      @(negedge clk);
      op_req = 1; reg_we = 1; reg_sel = 3'd5;
      @(negedge clk);
      op_req = 0; reg_we = 0;
      chk(reject == 1, "R6 set wins", reject, 1);
      while (busy) @(negedge clk);
      @(negedge clk);
      wr(3'd5, 0);
    end

    // R7/R8 ownership
    wr(3'd4, 1);
    chk(host_grant && !emu_grant, "R7 host owns", {emu_grant, host_grant}, 1);
    op_req = 1; op_kind = 2'd0;
    @(negedge clk);
    op_req = 0;
    chk(!busy && !done && !reject, "R8 blocked", {busy, done, reject}, 0);
    @(negedge clk);
    chk(!busy && !done, "R8 still idle", {busy, done}, 0);
    wr(3'd4, 0);
    chk(emu_grant && !host_grant, "R7 emu owns", {emu_grant, host_grant}, 2);

    // random mix
    void'($urandom(32'd1234));
    for (int it = 0; it < 40; it++) begin
      logic [2:0] t;
      logic [1:0] k;
      t = 3'($urandom_range(0, 7));
      k = 2'($urandom_range(0, 3));
      wr({1'b0, k}, 32'($urandom_range(0, 20)));
      cfg_dev_type = t;
      run_op(k, exp_len(t, k), (t == 3'd2) ? "R4 random" : "R2 random");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule